// File: doc/BRIEF.md
# Upset-Tolerant Dual-Copy Register File

This block is a processor register file that keeps working while single-event upsets corrupt its storage. It offers two synchronous read ports and one write port over 136 words of 32 bits. Every written word gets one even-parity bit per byte. The word and its four parity bits are then stored in two independent banks, A and B.

A read takes the same single cycle that an unprotected file would take. Bank A is the primary copy. When its word fails parity, the block returns bank B's word in the same cycle and raises a restart strobe, so that the pipeline re-issues the instruction that consumed the operand. If bank B is also bad, a fatal flag is raised as well. A correctable error queues a scrub. The clean word from bank B is written back into both banks in the first cycle in which the write port is idle, so the re-issued read finds clean data. A test mask flips chosen parity bits on ordinary writes, so that faults can be planted in either bank.

Top module: `seu_regfile`

## Requirements
- R1: Data presented with `wr_en` is read back unchanged on either read port. The read data appears in the cycle after the cycle in which `rd_en` and the address were sampled.
- R2: When a read and a write hit the same address in the same cycle, the read returns the contents from before the write.
- R3: Parity bit i of a stored word is the XOR of data bits 8i+7..8i, so each byte together with its parity bit has even weight. Bit i of `inj_a` or `inj_b` inverts parity bit i of the bank A or bank B copy on an ordinary write, and a read then sees that byte as failing.
- R4: A read whose bank A word fails parity asserts `rd_restart` for that port. In the same cycle it returns bank B's data.
- R5: A read whose bank A word passes parity returns bank A's data with no flag raised, whatever the state of bank B.
- R6: A read whose bank A and bank B words both fail parity asserts `rd_fatal` together with `rd_restart`.
- R7: A correctable error (A bad, B good) queues a write-back of B's data into both banks with fresh parity. Each read port has one queue slot. A write-back takes place only in a cycle with `wr_en` low, and port 0's slot is served before port 1's.
- R8: A queued write-back is dropped when an ordinary write reaches its address first. No write-back is queued when that address is written in the cycle the error is flagged, or in the cycle the faulty read was sampled.
- R9: Writes to addresses 136 and above change nothing. Reads of such addresses return zero with no flags.
- R10: After synchronous reset, every read port outputs zero data with no flags, and no write-back is pending.
- R11: The injection masks act only on ordinary writes. A write-back always stores correct parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| inj_a | input | 4 | Parity-flip mask for bank A on ordinary writes |
| inj_b | input | 4 | Parity-flip mask for bank B on ordinary writes |
| rd_en | input | 2 | Read enable per port |
| rd_addr | input | 2x8 | Read address per port |
| rd_data | output | 2x32 | Read data per port |
| rd_restart | output | 2 | Bank A parity error on the read: re-issue request |
| rd_fatal | output | 2 | Both copies failed parity |

## Verification
The bench aims at the write-back timing. A read issued while a write-back is being written, or issued behind a blocked lower-priority slot, must still see the faulty word. A design that served the slots in the wrong order, or let a write-back go out during an ordinary write, would show a clean word one cycle early or lose data. A second target is a stale write-back. Writing the pending address, or reading and writing it in the same cycle, must leave the newer data in place; a design that kept the queued entry would restore the old value. Planted faults in each byte lane, faults in bank B only, double faults and out-of-range addresses check the copy selection and flags. The bench also holds injection masks high during a write-back, which would catch a write-back that carried bad parity.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_NONE = 2'd2
  } pick_e;
endpackage

// File: rtl/rf_par_enc.sv
module rf_par_enc
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LANES-1:0]  flip,
  output logic [LANES-1:0]  par
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign par[l] = (^data[l*LANE_W +: LANE_W]) ^ flip[l];
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DEPTH = 136,
  parameter int AW    = 8,
  parameter int CW    = 36,
  parameter int NRD   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [CW-1:0]            wcw,
  input  logic [NRD-1:0]           re,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][CW-1:0]   rcw
);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [CW-1:0] mem [DEPTH];
  logic          w_ok;

  assign w_ok = ({1'b0, waddr} < LIMIT);

  always_ff @(posedge clk) begin
    if (we && w_ok) mem[waddr] <= wcw;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic          r_ok;
    logic [CW-1:0] q;
    assign r_ok = ({1'b0, raddr[p]} < LIMIT);
    always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (re[p]) q <= r_ok ? mem[raddr[p]] : '0;
    end
    assign rcw[p] = q;

    // R9
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (re[p] && !r_ok) |=> (rcw[p] == '0));
  end
endmodule

// File: rtl/rf_rd_check.sv
module rf_rd_check
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / LANE_W,
  parameter int CW     = DATA_W + LANES
) (
  input  logic              vld,
  input  logic              stale,
  input  logic [CW-1:0]     cw_a,
  input  logic [CW-1:0]     cw_b,
  output logic [DATA_W-1:0] data,
  output logic              restart,
  output logic              fatal,
  output logic              scrub_req,
  output logic [DATA_W-1:0] scrub_data
);
  logic [LANES-1:0] syn_a, syn_b;
  logic             bad_a, bad_b;
  pick_e            sel;

  for (genvar l = 0; l < LANES; l++) begin : g_syn
    assign syn_a[l] = ^{cw_a[DATA_W+l], cw_a[l*LANE_W +: LANE_W]};
    assign syn_b[l] = ^{cw_b[DATA_W+l], cw_b[l*LANE_W +: LANE_W]};
  end

  assign bad_a = |syn_a;
  assign bad_b = |syn_b;

  always_comb begin
    if (!bad_a)      sel = PICK_A;
    else if (!bad_b) sel = PICK_B;
    else             sel = PICK_NONE;
  end

  assign data       = (sel == PICK_A) ? cw_a[DATA_W-1:0] : cw_b[DATA_W-1:0];
  assign restart    = vld && (sel != PICK_A);
  assign fatal      = vld && (sel == PICK_NONE);
  assign scrub_req  = vld && (sel == PICK_B) && !stale;
  assign scrub_data = cw_b[DATA_W-1:0];
endmodule

// File: rtl/rf_scrub.sv
module rf_scrub #(
  parameter int NRD    = 2,
  parameter int AW     = 8,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NRD-1:0]              req,
  input  logic [NRD-1:0][AW-1:0]      req_addr,
  input  logic [NRD-1:0][DATA_W-1:0]  req_data,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  output logic                        sc_we,
  output logic [AW-1:0]               sc_addr,
  output logic [DATA_W-1:0]           sc_data
);
  logic [NRD-1:0]             sv, served;
  logic [NRD-1:0][AW-1:0]     sa;
  logic [NRD-1:0][DATA_W-1:0] sd;

  // lowest-numbered pending slot wins the idle write port
  always_comb begin
    logic found;
    found   = 1'b0;
    served  = '0;
    sc_addr = sa[0];
    sc_data = sd[0];
    for (int i = 0; i < NRD; i++) begin
      if (sv[i] && !found) begin
        found     = 1'b1;
        served[i] = !wr_en;
        sc_addr   = sa[i];
        sc_data   = sd[i];
      end
    end
    sc_we = found && !wr_en;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_slot
    logic              v_q;
    logic [AW-1:0]     a_q;
    logic [DATA_W-1:0] d_q;
    logic              hit, new_hit;
    assign hit     = wr_en && (wr_addr == a_q);
    assign new_hit = wr_en && (wr_addr == req_addr[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
      end else if (v_q) begin
        if (served[i] || hit) v_q <= 1'b0;
      end else if (req[i] && !new_hit) begin
        v_q <= 1'b1;
        a_q <= req_addr[i];
        d_q <= req_data[i];
      end
    end
    assign sv[i] = v_q;
    assign sa[i] = a_q;
    assign sd[i] = d_q;

    // R8
    cancel_on_write_chk: assert property (@(posedge clk) disable iff (rst)
      (sv[i] && wr_en && wr_addr == sa[i]) |=> !sv[i]);
  end

  // R7
  drain_first_chk: assert property (@(posedge clk) disable iff (rst)
    (sv[0] && !wr_en) |=> !sv[0]);

  // R7
  idle_port_only_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(served) != 0) |-> !wr_en);

  // R7
  one_served_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(served));
endmodule

// File: rtl/seu_regfile.sv
module seu_regfile
  import rf_pkg::*;
#(
  parameter int DEPTH  = 136,
  parameter int DATA_W = 32,
  parameter int NRD    = 2,
  localparam int LANES = DATA_W / LANE_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = DATA_W + LANES
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [LANES-1:0]            inj_a,
  input  logic [LANES-1:0]            inj_b,
  input  logic [NRD-1:0]              rd_en,
  input  logic [NRD-1:0][AW-1:0]      rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]  rd_data,
  output logic [NRD-1:0]              rd_restart,
  output logic [NRD-1:0]              rd_fatal
);
  logic                        sc_we;
  logic [AW-1:0]               sc_addr;
  logic [DATA_W-1:0]           sc_data;
  logic                        w_we;
  logic [AW-1:0]               w_addr;
  logic [DATA_W-1:0]           w_data;
  logic [LANES-1:0]            flip_a, flip_b, par_a, par_b;
  logic [NRD-1:0][CW-1:0]      cw_a, cw_b;
  logic [NRD-1:0]              scrub_req;
  logic [NRD-1:0][AW-1:0]      addr_q;
  logic [NRD-1:0][DATA_W-1:0]  scrub_data;

  // ordinary write owns the port; write-back uses idle cycles only
  assign w_we   = wr_en || sc_we;
  assign w_addr = wr_en ? wr_addr : sc_addr;
  assign w_data = wr_en ? wr_data : sc_data;
  assign flip_a = wr_en ? inj_a : '0;
  assign flip_b = wr_en ? inj_b : '0;

  rf_par_enc #(.DATA_W(DATA_W), .LANES(LANES)) u_enc_a (
    .data(w_data), .flip(flip_a), .par(par_a));
  rf_par_enc #(.DATA_W(DATA_W), .LANES(LANES)) u_enc_b (
    .data(w_data), .flip(flip_b), .par(par_b));

  rf_bank #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .NRD(NRD)) u_bank_a (
    .clk(clk), .rst(rst), .we(w_we), .waddr(w_addr), .wcw({par_a, w_data}),
    .re(rd_en), .raddr(rd_addr), .rcw(cw_a));
  rf_bank #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .NRD(NRD)) u_bank_b (
    .clk(clk), .rst(rst), .we(w_we), .waddr(w_addr), .wcw({par_b, w_data}),
    .re(rd_en), .raddr(rd_addr), .rcw(cw_b));

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic          vld_q, stale_q;
    logic [AW-1:0] a_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q   <= 1'b0;
        stale_q <= 1'b0;
        a_q     <= '0;
      end else begin
        vld_q   <= rd_en[p];
        stale_q <= rd_en[p] && wr_en && (wr_addr == rd_addr[p]);
        if (rd_en[p]) a_q <= rd_addr[p];
      end
    end
    assign addr_q[p] = a_q;

    rf_rd_check #(.DATA_W(DATA_W), .LANES(LANES), .CW(CW)) u_chk (
      .vld(vld_q), .stale(stale_q), .cw_a(cw_a[p]), .cw_b(cw_b[p]),
      .data(rd_data[p]), .restart(rd_restart[p]), .fatal(rd_fatal[p]),
      .scrub_req(scrub_req[p]), .scrub_data(scrub_data[p]));

    // R4
    restart_after_read_chk: assert property (@(posedge clk) disable iff (rst)
      rd_restart[p] |-> $past(rd_en[p]));

    // R6
    fatal_with_restart_chk: assert property (@(posedge clk) disable iff (rst)
      rd_fatal[p] |-> rd_restart[p]);
  end

  rf_scrub #(.NRD(NRD), .AW(AW), .DATA_W(DATA_W)) u_scrub (
    .clk(clk), .rst(rst), .req(scrub_req), .req_addr(addr_q),
    .req_data(scrub_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .sc_we(sc_we), .sc_addr(sc_addr), .sc_data(sc_data));
endmodule

// File: tb/test_seu_regfile.sv
module test_seu_regfile;
  localparam int DEPTH = 136;

  logic            clk = 1'b0;
  logic            rst;
  logic            b_we;
  logic [7:0]      b_wa;
  logic [31:0]     b_wd;
  logic [3:0]      b_ia, b_ib;
  logic [1:0]      b_re;
  logic [1:0][7:0] b_ra;
  logic [1:0][31:0] rd_data;
  logic [1:0]      rd_restart, rd_fatal;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R10";

  always #5 clk = ~clk;

  seu_regfile i_seu_regfile (
    .clk(clk), .rst(rst), .wr_en(b_we), .wr_addr(b_wa), .wr_data(b_wd),
    .inj_a(b_ia), .inj_b(b_ib), .rd_en(b_re), .rd_addr(b_ra),
    .rd_data(rd_data), .rd_restart(rd_restart), .rd_fatal(rd_fatal));

  // behavioural reference state
  logic [35:0] mA [DEPTH];
  logic [35:0] mB [DEPTH];
  logic [35:0] cwA [2];
  logic [35:0] cwB [2];
  bit          mv [2];
  bit          mst [2];
  int          mad [2];
  bit          sv [2];
  int          sa [2];
  logic [31:0] sd [2];

  function automatic logic [3:0] par4(logic [31:0] d);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  function automatic bit bad(logic [35:0] cw);
    for (int b = 0; b < 4; b++) if (^{cw[32+b], cw[b*8 +: 8]}) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_update();
    bit cap [2];
    bit scw;
    int sel;
    if (rst) begin
      for (int p = 0; p < 2; p++) begin
        cwA[p] = '0; cwB[p] = '0; mv[p] = 0; mst[p] = 0; sv[p] = 0; mad[p] = 0;
      end
      return;
    end
    for (int p = 0; p < 2; p++)
      cap[p] = mv[p] && bad(cwA[p]) && !bad(cwB[p]) && !mst[p] &&
               !(b_we && int'(b_wa) == mad[p]);
    scw = !b_we && (sv[0] || sv[1]);
    sel = sv[0] ? 0 : 1;
    for (int p = 0; p < 2; p++) begin
      bit was;
      was = sv[p];
      if (was && ((scw && sel == p) || (b_we && int'(b_wa) == sa[p]))) sv[p] = 0;
      if (!was && cap[p]) begin
        sv[p] = 1; sa[p] = mad[p]; sd[p] = cwB[p][31:0];
      end
    end
    for (int p = 0; p < 2; p++) begin
      mv[p]  = b_re[p];
      mst[p] = b_re[p] && b_we && (b_wa == b_ra[p]);
      if (b_re[p]) begin
        mad[p] = int'(b_ra[p]);
        cwA[p] = (mad[p] < DEPTH) ? mA[mad[p]] : '0;
        cwB[p] = (mad[p] < DEPTH) ? mB[mad[p]] : '0;
      end
    end
    if (b_we) begin
      if (int'(b_wa) < DEPTH) begin
        mA[b_wa] = {par4(b_wd) ^ b_ia, b_wd};
        mB[b_wa] = {par4(b_wd) ^ b_ib, b_wd};
      end
    end else if (scw) begin
      mA[sa[sel]] = {par4(sd[sel]), sd[sel]};
      mB[sa[sel]] = {par4(sd[sel]), sd[sel]};
    end
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 2; p++) begin
      bit ba, bb;
      ba = bad(cwA[p]);
      bb = bad(cwB[p]);
      chk($sformatf("port%0d data", p), rd_data[p], ba ? cwB[p][31:0] : cwA[p][31:0]);
      chk($sformatf("port%0d restart", p), 32'(rd_restart[p]), 32'(mv[p] && ba));
      chk($sformatf("port%0d fatal", p), 32'(rd_fatal[p]), 32'(mv[p] && ba && bb));
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    b_we = 0; b_wa = '0; b_wd = '0; b_ia = '0; b_ib = '0; b_re = '0; b_ra = '0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin quiet(); cyc(); end
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] ia, logic [3:0] ib);
    quiet(); b_we = 1; b_wa = 8'(a); b_wd = d; b_ia = ia; b_ib = ib; cyc();
  endtask

  task automatic rd(int a0, int a1);
    quiet(); b_re = 2'b11; b_ra[0] = 8'(a0); b_ra[1] = 8'(a1); cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    quiet();
    rst = 1;
    // R10: reset state
    cur_req = "R10";
    idle(3);
    rst = 0;
    idle(1);

    // R1: fill every entry, read back on both ports
    cur_req = "R1";
    for (int i = 0; i < DEPTH; i++) wr(i, $urandom, 4'h0, 4'h0);
    for (int i = 0; i < DEPTH; i++) rd(i, DEPTH - 1 - i);
    idle(1);

    // R2: read and write same address in the same cycle
    cur_req = "R2";
    quiet(); b_we = 1; b_wa = 8'd5; b_wd = 32'hA5A5_0F0F;
    b_re = 2'b11; b_ra[0] = 8'd5; b_ra[1] = 8'd5; cyc();
    rd(5, 5);

    // R3: each parity lane flipped in bank A is detected
    cur_req = "R3";
    for (int l = 0; l < 4; l++) wr(20 + l, 32'h1234_5678 + l, 4'(1 << l), 4'h0);
    for (int l = 0; l < 4; l++) begin rd(20 + l, 0); idle(1); end

    // R4 and R7: single bank A fault, write-back, clean re-read
    cur_req = "R4";
    wr(10, 32'hDEAD_BEEF, 4'b0100, 4'h0);
    rd(10, 10);
    cur_req = "R7";
    idle(1);
    rd(10, 10);

    // R5: bank B fault alone is invisible
    cur_req = "R5";
    wr(30, 32'h0BAD_F00D, 4'h0, 4'b1001);
    rd(30, 30);

    // R6: both copies bad, no write-back possible
    cur_req = "R6";
    wr(40, 32'h4040_4040, 4'b0001, 4'b0010);
    rd(40, 0);
    idle(2);
    rd(0, 40);

    // R7: slot priority, port 0 drained before port 1
    cur_req = "R7";
    wr(50, 32'h5050_0050, 4'b1000, 4'h0);
    wr(51, 32'h5151_0051, 4'b0010, 4'h0);
    rd(50, 51);
    wr(100, 32'h0000_0100, 4'h0, 4'h0);
    idle(1);
    rd(50, 51);
    rd(50, 51);

    // R8: write in the flag cycle suppresses the write-back
    cur_req = "R8";
    wr(60, 32'h6060_6060, 4'b0001, 4'h0);
    rd(60, 0);
    wr(60, 32'h6161_6161, 4'h0, 4'h0);
    idle(2);
    rd(60, 60);
    // R8: write to a pending address cancels the entry
    wr(61, 32'h6262_6262, 4'b0100, 4'h0);
    rd(61, 0);
    wr(101, 32'h0000_0101, 4'h0, 4'h0);
    wr(61, 32'h6363_6363, 4'h0, 4'h0);
    idle(2);
    rd(61, 61);
    // R8: read sampled with a same-address write gets no write-back
    wr(62, 32'h6464_6464, 4'b0010, 4'h0);
    quiet(); b_we = 1; b_wa = 8'd62; b_wd = 32'h6565_6565;
    b_re = 2'b01; b_ra[0] = 8'd62; cyc();
    idle(2);
    rd(62, 62);

    // R9: out-of-range addresses
    cur_req = "R9";
    wr(200, 32'hFFFF_FFFF, 4'h0, 4'h0);
    wr(136, 32'hEEEE_EEEE, 4'h0, 4'h0);
    rd(200, 136);
    rd(255, 135);

    // R11: injection masks ignored during a write-back
    cur_req = "R11";
    wr(70, 32'h7070_7070, 4'b1111, 4'h0);
    rd(70, 0);
    quiet(); b_ia = 4'hF; b_ib = 4'hF; cyc();
    quiet(); b_ia = 4'hF; b_ib = 4'hF; cyc();
    rd(70, 70);

    // R10: reset clears outputs and pending write-backs
    cur_req = "R10";
    wr(80, 32'h8080_8080, 4'b0001, 4'h0);
    rd(80, 0);
    rst = 1; idle(2); rst = 0;
    idle(2);
    rd(80, 80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule